// File: doc/BRIEF.md
# USB Root Hub Downstream Port Status Register

This block keeps the state of one downstream port of a USB host root hub and presents it to the host controller driver as a single 32-bit register. Reading the register returns live port state (connection, enable, suspend, reset in progress, overcurrent, device speed, power) and five sticky change flags that record hardware events. Writing the register issues commands instead: a 1 in a low bit requests an action such as enabling the port, suspending it, resuming it, resetting it or disabling it. The same bit position can therefore mean one thing when read and something else when written. A 1 written to a change flag clears that flag.

The port reset and the resume are timed from a one-millisecond tick input. A reset holds a drive strobe toward the PHY for a set number of ticks. A resume holds its own drive strobe, then asks for an end-of-packet for one cycle, then waits out a short resynchronisation delay. The change flag of a sequence is raised only when the whole sequence is over. A disconnect takes the port out of the enabled state, records that fact in two change flags and cancels any sequence in flight. Line signalling itself belongs to the PHY.

Top module: `rh_port_ctl`

## Requirements
- R1: Bits 31:21, 15:10 and 7:5 of `rd_data` always read 0. Bit 8 (port powered) always reads 1. After reset the register reads 0x0000_0100.
- R2: Bit 0 reads the value `conn_in` had at the previous clock edge. Bit 9 reads the registered `lowspeed_in` ANDed with bit 0. Bit 16 (connect change) is set whenever bit 0 changes value.
- R3: Writing 1 to any of bits 20:16 clears that change flag. Writing 0 to those bits leaves them unchanged.
- R4: Writing 1 to bit 0 clears the enable status (read bit 1) without setting bit 17. Writing 1 to bit 1 sets the enable status, but only while bit 0 reads 1.
- R5: Writing 1 to bit 4 while connected starts a port reset. Read bit 4 and `reset_drive` stay at 1 until the RESET_MS-th tick after the start. At that edge read bit 4 goes to 0, bit 20 goes to 1, bit 1 goes to 1 and bit 2 goes to 0, all together. A reset command is ignored while disconnected.
- R6: Writing 1 to bit 2 while enabled sets the suspend status (read bit 2). Writing 1 to bit 3 while suspended starts a resume, which runs in this order:
  - `resume_drive` is high until the RESUME_MS-th tick.
  - `eop_req` is high for exactly the next cycle.
  - After RESYNC_MS further ticks, bit 2 goes to 0 and bit 18 goes to 1 in the same cycle.
  - Bit 18 stays 0 until that point.
- R7: With per-port overcurrent reporting, bit 3 reads the `ovc_in` value from the previous edge, and bit 19 is set on every change of bit 3.
- R8: A disconnect while enabled clears bit 1 and sets both bit 17 and bit 16. It also cancels a reset or resume in progress, so that sequence never sets its change flag.
- R9: Bit 17 is set only by a hardware-caused loss of enable, never by a host write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 32 | Write value: commands in the low bits, clear-on-1 flags in bits 20:16 |
| rd_data | output | 32 | Read value: status and change flags |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| conn_in | input | 1 | Device present on the port |
| lowspeed_in | input | 1 | Attached device is low speed |
| ovc_in | input | 1 | Port overcurrent indication |
| reset_drive | output | 1 | Request to the PHY to drive port reset |
| resume_drive | output | 1 | Request to the PHY to drive resume signalling |
| eop_req | output | 1 | One-cycle request for an end-of-packet after resume |

## Verification
The reset and resume timers are swept one tick at a time. At every tick the full register is compared with a model, which separates an off-by-one tick count from a correct one, and separates a change flag raised early from one raised at the end. The overcurrent input is toggled in both directions several times, with the flag cleared in between, so that edge detection, level following and the clear-on-1 flags are all tried. Enable is cleared once by a host write and once by a disconnect in the middle of a reset. This tells the hardware-only enable-change flag apart from a plain copy of the enable bit, and shows that an aborted sequence never completes. Commands given while disconnected show that the guard conditions hold.

// File: rtl/rhp_pkg.sv
package rhp_pkg;
   // Register bit positions; software decodes these
   localparam int B_CCS  = 0;
   localparam int B_PES  = 1;
   localparam int B_PSS  = 2;
   localparam int B_POCI = 3;
   localparam int B_PRS  = 4;
   localparam int B_PWR  = 8;
   localparam int B_LSD  = 9;
   localparam int B_CHG0 = 16;
   localparam int N_CHG  = 5;

   // Write command bits
   localparam int W_CLR_EN   = 0;
   localparam int W_SET_EN   = 1;
   localparam int W_SUSPEND  = 2;
   localparam int W_RESUME   = 3;
   localparam int W_RESET    = 4;

   // Index of each change flag within the change group (bit = B_CHG0 + index)
   localparam int C_CONN  = 0;
   localparam int C_EN    = 1;
   localparam int C_SUSP  = 2;
   localparam int C_OVC   = 3;
   localparam int C_RST   = 4;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_DRIVE  = 2'd1,
      SEQ_EOP    = 2'd2,
      SEQ_SETTLE = 2'd3
   } seq_state_e;
endpackage

// File: rtl/rhp_seq_timer.sv
module rhp_seq_timer
   import rhp_pkg::*;
#(
   parameter int PHASE1 = 10,
   parameter bit EOP_EN = 1'b0,
   parameter int PHASE2 = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic start,
   input  logic abort,
   output logic busy,
   output logic drive,
   output logic eop,
   output logic finish
);
   localparam int LONGEST = (PHASE1 > PHASE2) ? PHASE1 : PHASE2;
   localparam int CW      = $clog2(LONGEST + 1);

   if (PHASE1 < 1) begin : g_bad_p1
      $error("rhp_seq_timer: PHASE1 must be at least 1");
   end
   if (PHASE2 < 1) begin : g_bad_p2
      $error("rhp_seq_timer: PHASE2 must be at least 1");
   end

   seq_state_e    state;
   logic [CW-1:0] cnt;
   logic          p1_last;
   logic          p2_last;
   logic          seq_last;

   assign p1_last = (state == SEQ_DRIVE)  && tick && (cnt == CW'(PHASE1 - 1));
   assign p2_last = (state == SEQ_SETTLE) && tick && (cnt == CW'(PHASE2 - 1));

   if (EOP_EN) begin : g_with_eop
      assign seq_last = p2_last;
   end else begin : g_no_eop
      assign seq_last = p1_last;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         cnt   <= '0;
      end else if (abort) begin
         state <= SEQ_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            SEQ_IDLE: begin
               if (start) begin
                  state <= SEQ_DRIVE;
                  cnt   <= '0;
               end
            end
            SEQ_DRIVE: begin
               if (p1_last) begin
                  cnt   <= '0;
                  state <= EOP_EN ? SEQ_EOP : SEQ_IDLE;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            SEQ_EOP: begin
               state <= SEQ_SETTLE;
               cnt   <= '0;
            end
            SEQ_SETTLE: begin
               if (p2_last) begin
                  state <= SEQ_IDLE;
                  cnt   <= '0;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign busy   = (state != SEQ_IDLE);
   assign drive  = (state == SEQ_DRIVE);
   assign eop    = (state == SEQ_EOP);
   assign finish = seq_last && !abort;
endmodule

// File: rtl/rhp_change_flag.sv
module rhp_change_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   // A hardware event in the same cycle as a host clear wins
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/rh_port_ctl.sv
module rh_port_ctl
   import rhp_pkg::*;
#(
   parameter int RESET_MS    = 10,
   parameter int RESUME_MS   = 20,
   parameter int RESYNC_MS   = 3,
   parameter bit PER_PORT_OC = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   output logic [31:0] rd_data,
   input  logic        ms_tick,
   input  logic        conn_in,
   input  logic        lowspeed_in,
   input  logic        ovc_in,
   output logic        reset_drive,
   output logic        resume_drive,
   output logic        eop_req
);
   logic ccs, pes, pss, poci, ls_q;
   logic disc, conn_chg, pes_hw_clr;
   logic rst_busy, rst_drv, rst_eop_unused, rst_fin;
   logic res_busy, res_drv, res_eop, res_fin;
   logic rst_start, res_start;
   logic [N_CHG-1:0] chg_set, chg_clr, chg_q;
   logic cmd_clr_en, cmd_set_en, cmd_susp, cmd_resume, cmd_reset;

   assign cmd_clr_en = wr_en && wr_data[W_CLR_EN];
   assign cmd_set_en = wr_en && wr_data[W_SET_EN];
   assign cmd_susp   = wr_en && wr_data[W_SUSPEND];
   assign cmd_resume = wr_en && wr_data[W_RESUME];
   assign cmd_reset  = wr_en && wr_data[W_RESET];

   assign conn_chg   = (conn_in != ccs);
   assign disc       = ccs && !conn_in;
   assign pes_hw_clr = disc && pes;

   assign rst_start = cmd_reset && ccs && !disc;
   assign res_start = cmd_resume && pss && !disc;

   rhp_seq_timer #(.PHASE1(RESET_MS), .EOP_EN(1'b0), .PHASE2(1)) u_rst_seq (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick), .start(rst_start), .abort(disc),
      .busy(rst_busy), .drive(rst_drv), .eop(rst_eop_unused), .finish(rst_fin)
   );

   rhp_seq_timer #(.PHASE1(RESUME_MS), .EOP_EN(1'b1), .PHASE2(RESYNC_MS)) u_res_seq (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick), .start(res_start), .abort(disc),
      .busy(res_busy), .drive(res_drv), .eop(res_eop), .finish(res_fin)
   );

   // Live status
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ccs  <= 1'b0;
         ls_q <= 1'b0;
         pes  <= 1'b0;
         pss  <= 1'b0;
      end else begin
         ccs  <= conn_in;
         ls_q <= lowspeed_in;
         if (disc)                    pes <= 1'b0;
         else if (rst_fin)            pes <= 1'b1;
         else if (cmd_clr_en)         pes <= 1'b0;
         else if (cmd_set_en && ccs)  pes <= 1'b1;

         if (disc || rst_fin || res_fin)             pss <= 1'b0;
         else if (cmd_susp && pes && !rst_busy)      pss <= 1'b1;
      end
   end

   if (PER_PORT_OC) begin : g_oc_port
      always_ff @(posedge clk) begin
         if (!rst_n) poci <= 1'b0;
         else        poci <= ovc_in;
      end
      assign chg_set[C_OVC] = (ovc_in != poci);
   end else begin : g_oc_global
      assign poci = 1'b0;
      assign chg_set[C_OVC] = 1'b0;
   end

   assign chg_set[C_CONN] = conn_chg;
   assign chg_set[C_EN]   = pes_hw_clr;
   assign chg_set[C_SUSP] = res_fin;
   assign chg_set[C_RST]  = rst_fin;
   assign chg_clr = wr_en ? wr_data[B_CHG0 +: N_CHG] : '0;

   for (genvar i = 0; i < N_CHG; i++) begin : g_chg
      rhp_change_flag u_flag (
         .clk(clk), .rst_n(rst_n), .set(chg_set[i]), .clr(chg_clr[i]), .q(chg_q[i])
      );
   end

   always_comb begin
      rd_data                     = '0;
      rd_data[B_CCS]              = ccs;
      rd_data[B_PES]              = pes;
      rd_data[B_PSS]              = pss;
      rd_data[B_POCI]             = poci;
      rd_data[B_PRS]              = rst_busy;
      rd_data[B_PWR]              = 1'b1;
      rd_data[B_LSD]              = ccs && ls_q;
      rd_data[B_CHG0 +: N_CHG]    = chg_q;
   end

   assign reset_drive  = rst_drv;
   assign resume_drive = res_drv;
   assign eop_req      = res_eop;

   logic unused_bits;
   assign unused_bits = ^{wr_data[31:21], wr_data[15:5], rst_eop_unused, res_busy};
endmodule

module rh_port_ctl_chk #(
   parameter bit PER_PORT_OC = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [31:0] wr_data,
   input logic [31:0] rd_data,
   input logic        conn_in,
   input logic        ovc_in,
   input logic        reset_drive,
   input logic        resume_drive,
   input logic        eop_req
);
   assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[31:21] == '0) && (rd_data[15:10] == '0) && (rd_data[7:5] == '0) && rd_data[8]);

   assert_connect_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[0] == $past(conn_in));

   assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[16] && rd_data[16] && (conn_in == rd_data[0])) |=> !rd_data[16]);

   assert_reset_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[20]) |-> ($fell(rd_data[4]) && rd_data[1] && !rd_data[2]));

   assert_reset_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reset_drive == rd_data[4]);

   assert_eop_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      eop_req |=> !eop_req);

   assert_eop_after_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eop_req) |-> $past(resume_drive));

   assert_resume_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[18]) |-> $fell(rd_data[2]));

   assert_pesc_hw_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[17]) |-> ($past(rd_data[0]) && !$past(conn_in) && $past(rd_data[1])));

   assert_disc_cancels_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[0] && !conn_in) |=> (!rd_data[1] && !rd_data[4] && !resume_drive));

   if (PER_PORT_OC) begin : g_oc_chk
      assert_oc_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
         rd_data[3] == $past(ovc_in));
   end
endmodule

bind rh_port_ctl rh_port_ctl_chk #(.PER_PORT_OC(PER_PORT_OC)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
   .conn_in(conn_in), .ovc_in(ovc_in), .reset_drive(reset_drive),
   .resume_drive(resume_drive), .eop_req(eop_req)
);

// File: tb/rh_port_ctl_test.sv
`timescale 1ns/1ps
module rh_port_ctl_test;
   localparam int RST_T = 10;
   localparam int RES_T = 20;
   localparam int SYN_T = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic ms_tick = 1'b0;
   logic conn_in = 1'b0;
   logic lowspeed_in = 1'b0;
   logic ovc_in = 1'b0;
   logic reset_drive, resume_drive, eop_req;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // Bench model of the register
   bit m_ccs, m_pes, m_pss, m_poci, m_prs, m_ls;
   bit m_csc, m_pesc, m_pssc, m_ocic, m_prsc;

   always #2.5 clk = ~clk;

   rh_port_ctl #(.RESET_MS(RST_T), .RESUME_MS(RES_T), .RESYNC_MS(SYN_T), .PER_PORT_OC(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .ms_tick(ms_tick), .conn_in(conn_in), .lowspeed_in(lowspeed_in), .ovc_in(ovc_in),
      .reset_drive(reset_drive), .resume_drive(resume_drive), .eop_req(eop_req)
   );

   function automatic logic [31:0] model();
      logic [31:0] v = 32'h0000_0100;
      v[0] = m_ccs; v[1] = m_pes; v[2] = m_pss; v[3] = m_poci; v[4] = m_prs;
      v[9] = m_ccs & m_ls;
      v[16] = m_csc; v[17] = m_pesc; v[18] = m_pssc; v[19] = m_ocic; v[20] = m_prsc;
      return v;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_reg(input string req);
      check(req, rd_data, model());
   endtask

   task automatic write(input logic [31:0] d);
      @(negedge clk); wr_data = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic tick();
      @(negedge clk); ms_tick = 1'b1;
      @(negedge clk); ms_tick = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(1);
      check("R1 reset value", rd_data, 32'h0000_0100);

      // Connect a low-speed device
      @(negedge clk); conn_in = 1'b1; lowspeed_in = 1'b1;
      @(negedge clk);
      m_ccs = 1; m_ls = 1; m_csc = 1;
      check_reg("R2 connect");
      check("R2 connect raw", rd_data, 32'h0001_0301);

      write(32'h0);
      check_reg("R3 zero write keeps flags");
      write(32'h0001_0000);
      m_csc = 0;
      check_reg("R3 clear connect change");

      write(32'h0000_0002);
      m_pes = 1;
      check_reg("R4 set enable");
      write(32'h0000_0001);
      m_pes = 0;
      check_reg("R4 R9 host disable no change flag");
      write(32'h0000_0002);
      m_pes = 1;

      // Reset sequence sweep
      write(32'h0000_0010);
      m_prs = 1;
      check_reg("R5 reset started");
      check("R5 reset_drive", {31'b0, reset_drive}, 32'd1);
      for (int k = 1; k <= RST_T; k++) begin
         tick();
         if (k == RST_T) begin
            m_prs = 0; m_prsc = 1; m_pes = 1; m_pss = 0;
         end
         check_reg($sformatf("R5 reset tick %0d", k));
         check($sformatf("R5 reset_drive tick %0d", k), {31'b0, reset_drive}, {31'b0, m_prs});
      end
      write(32'h0010_0000);
      m_prsc = 0;
      check_reg("R3 clear reset change");

      // Suspend and resume sweep
      write(32'h0000_0004);
      m_pss = 1;
      check_reg("R6 suspend");
      write(32'h0000_0008);
      check("R6 resume_drive on", {31'b0, resume_drive}, 32'd1);
      for (int k = 1; k <= RES_T; k++) begin
         tick();
         check_reg($sformatf("R6 resume tick %0d", k));
         check($sformatf("R6 resume_drive tick %0d", k), {31'b0, resume_drive}, {31'b0, (k < RES_T)});
         check($sformatf("R6 eop tick %0d", k), {31'b0, eop_req}, {31'b0, (k == RES_T)});
      end
      idle(1);
      check("R6 eop one cycle", {31'b0, eop_req}, 32'd0);
      for (int k = 1; k <= SYN_T; k++) begin
         tick();
         if (k == SYN_T) begin
            m_pss = 0; m_pssc = 1;
         end
         check_reg($sformatf("R6 resync tick %0d", k));
      end
      write(32'h0004_0000);
      m_pssc = 0;
      check_reg("R3 clear suspend change");

      // Overcurrent toggles
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); ovc_in = ~ovc_in;
         @(negedge clk);
         m_poci = ovc_in; m_ocic = 1;
         check_reg($sformatf("R7 overcurrent toggle %0d", i));
         write(32'h0008_0000);
         m_ocic = 0;
         check_reg($sformatf("R7 R3 overcurrent clear %0d", i));
      end

      // Disconnect during a reset
      write(32'h0000_0010);
      m_prs = 1;
      for (int k = 0; k < 3; k++) tick();
      check_reg("R5 reset in progress");
      @(negedge clk); conn_in = 1'b0;
      @(negedge clk);
      m_ccs = 0; m_csc = 1; m_pes = 0; m_pesc = 1; m_prs = 0; m_pss = 0;
      check_reg("R8 R9 disconnect while enabled");
      for (int k = 0; k < RST_T; k++) tick();
      check_reg("R8 aborted reset never completes");

      write(32'h0000_0010);
      check_reg("R5 reset ignored while disconnected");
      check("R5 no reset_drive when disconnected", {31'b0, reset_drive}, 32'd0);
      write(32'h0000_0002);
      check_reg("R4 enable ignored while disconnected");
      write(32'h0003_0000);
      m_csc = 0; m_pesc = 0;
      check_reg("R3 clear two flags");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule